// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Trigger

This block decides the clock edge on which each new power-switch cycle of a valley-switched converter starts, and it drives the gate for a programmed on-time. Every interval is counted in clock edges from the edge on which the previous gate pulse rose. A minimum-period blanking window stops early restarts. After the window ends, the first qualified valley pulse starts the next cycle. If valleys arrived only inside the blanking window, a fallback timer starts the cycle a fixed number of edges after the window closes. If no valley qualifies at all, a long starter timeout restarts switching.

An enable input combines the under-voltage and fault conditions. While enable is low, the gate stays low and all timing state is cleared. After enable returns, only the starter timeout can issue the first cycle. The on-time comes from an input that is sampled at each cycle start and clamped to a parameter window.

Top module: `qr_cycle_trigger`

## Requirements
- R1: On a cycle start, `gate_o` rises and `start_o` is high in the same clock cycle. `gate_o` never rises without `start_o`.
- R2: Two consecutive cycle starts are never less than TMIN_CYC edges apart.
- R3: Number the edge on which the gate rose as edge 0. If `valley_i` is high at edge k, with k >= TMIN_CYC and `gate_o` low, a new cycle starts at edge k.
- R4: A valley sampled at edge k < TMIN_CYC while `gate_o` is low does not start a cycle. It arms a fallback. If no later valley qualifies, the cycle starts at edge TMIN_CYC+TFB_CYC.
- R5: If no valley qualifies and nothing is armed, the cycle starts at edge TSTART_CYC.
- R6: `gate_o` stays high for exactly T edges. T is `ton_i`, sampled at the start edge and clamped to the range TON_MIN to TON_MAX.
- R7: A valley sampled while `gate_o` is high is ignored and does not arm the fallback.
- R8: While `en_i` is sampled low, `gate_o` and `start_o` are low from the next cycle on, and any pending fallback is cleared.
- R9: After reset release, or after `en_i` returns high, the first start comes only from the starter. It occurs TSTART_CYC edges after the first edge at which `en_i` is sampled high. Valleys before that start are ignored.
- R10: When several start conditions meet on one edge, exactly one cycle starts. `start_o` is never high for two cycles in a row.
- R11: While `rst_ni` is low, `gate_o` and `start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable (low during undervoltage or a fault) |
| valley_i | input | 1 | Qualified valley pulse, sampled on each edge |
| ton_i | input | TON_W | Requested on-time in clock cycles |
| gate_o | output | 1 | Power switch gate drive |
| start_o | output | 1 | One-cycle strobe marking a cycle start |

## Verification
The bench places valleys exactly on the blanking boundary and one edge before it. A design with an off-by-one error would start a cycle one edge early, or would fall back to the timeout when it should not. The bench sends valleys only inside blanking, and checks that the restart lands on the fallback edge and not on the starter edge. It also lands a late valley on the same edge as the fallback, where a faulty design would issue two strobes. Valleys sent while the gate is high and during the start-up wait must leave the period at the full starter timeout; a design that armed on them would restart early. The bench also requests on-times below and above the clamp window, which would expose a gate pulse of the wrong width.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_VALLEY   = 2'd1,
    SRC_FALLBACK = 2'd2,
    SRC_STARTER  = 2'd3
  } trig_src_e;
endpackage

// File: rtl/qr_ival_timer.sv
module qr_ival_timer #(
  parameter int CNT_W  = 14,
  parameter int TMIN   = 850,
  parameter int TFB    = 500,
  parameter int TSTART = 13000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             blank_o,
  output logic             fb_due_o,
  output logic             start_due_o
);
  localparam logic [CNT_W-1:0] LIM_MIN = CNT_W'(TMIN);
  localparam logic [CNT_W-1:0] LIM_FB  = CNT_W'(TMIN + TFB);
  localparam logic [CNT_W-1:0] LIM_ST  = CNT_W'(TSTART);

  logic [CNT_W-1:0] elapsed_q;

  // elapsed_q holds k when edge k (counted from the rise) is about to occur
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                elapsed_q <= '0;
    else if (!en_i)             elapsed_q <= '0;
    else if (restart_i)         elapsed_q <= CNT_W'(1);
    else if (elapsed_q < LIM_ST) elapsed_q <= elapsed_q + CNT_W'(1);
  end

  assign elapsed_o   = elapsed_q;
  assign blank_o     = elapsed_q < LIM_MIN;
  assign fb_due_o    = elapsed_q >= LIM_FB;
  assign start_due_o = elapsed_q >= LIM_ST;
endmodule

// File: rtl/qr_trig_arb.sv
module qr_trig_arb
  import qr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valley_i,
  input  logic gate_i,
  input  logic blank_i,
  input  logic fb_due_i,
  input  logic start_due_i,
  output logic trig_o
);
  logic      boot_q, armed_q;
  trig_src_e src;

  // starter beats everything; during boot only the starter may fire
  always_comb begin
    src = SRC_NONE;
    if (start_due_i)                         src = SRC_STARTER;
    else if (!boot_q) begin
      if (valley_i && !gate_i && !blank_i)   src = SRC_VALLEY;
      else if (armed_q && fb_due_i)          src = SRC_FALLBACK;
    end
  end

  assign trig_o = en_i && (src != SRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      boot_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (trig_o) begin
      boot_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (valley_i && !gate_i && blank_i && !boot_q) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/qr_gate_drv.sv
module qr_gate_drv #(
  parameter int TON_W   = 10,
  parameter int CNT_W   = 14,
  parameter int TON_MIN = 20,
  parameter int TON_MAX = 600
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic [TON_W-1:0] ton_i,
  input  logic [CNT_W-1:0] elapsed_i,
  output logic             gate_o,
  output logic             start_o
);
  localparam logic [TON_W-1:0] T_LO = TON_W'(TON_MIN);
  localparam logic [TON_W-1:0] T_HI = TON_W'(TON_MAX);

  logic [TON_W-1:0] ton_c;
  logic [CNT_W-1:0] ton_q;
  logic             gate_q, start_q;

  always_comb begin
    if (ton_i < T_LO)      ton_c = T_LO;
    else if (ton_i > T_HI) ton_c = T_HI;
    else                   ton_c = ton_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      start_q <= 1'b0;
      ton_q   <= '0;
    end else if (!en_i) begin
      gate_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (trig_i) begin
      gate_q  <= 1'b1;
      start_q <= 1'b1;
      ton_q   <= CNT_W'(ton_c);
    end else begin
      start_q <= 1'b0;
      if (gate_q && elapsed_i >= ton_q) gate_q <= 1'b0;
    end
  end

  assign gate_o  = gate_q;
  assign start_o = start_q;
endmodule

// File: rtl/qr_cycle_trigger.sv
module qr_cycle_trigger #(
  parameter int TMIN_CYC   = 850,
  parameter int TFB_CYC    = 500,
  parameter int TSTART_CYC = 13000,
  parameter int TON_MIN    = 20,
  parameter int TON_MAX    = 600,
  parameter int TON_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valley_i,
  input  logic [TON_W-1:0] ton_i,
  output logic             gate_o,
  output logic             start_o
);
  localparam int CNT_W = $clog2(TSTART_CYC + 1);

  logic [CNT_W-1:0] elapsed;
  logic             blank, fb_due, start_due, trig, gate;

  qr_ival_timer #(
    .CNT_W(CNT_W), .TMIN(TMIN_CYC), .TFB(TFB_CYC), .TSTART(TSTART_CYC)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .restart_i(trig),
    .elapsed_o(elapsed), .blank_o(blank), .fb_due_o(fb_due),
    .start_due_o(start_due)
  );

  qr_trig_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valley_i(valley_i),
    .gate_i(gate), .blank_i(blank), .fb_due_i(fb_due),
    .start_due_i(start_due), .trig_o(trig)
  );

  qr_gate_drv #(
    .TON_W(TON_W), .CNT_W(CNT_W), .TON_MIN(TON_MIN), .TON_MAX(TON_MAX)
  ) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .trig_i(trig),
    .ton_i(ton_i), .elapsed_i(elapsed), .gate_o(gate), .start_o(start_o)
  );

  assign gate_o = gate;
endmodule

// File: rtl/qr_cycle_trigger_chk.sv
module qr_cycle_trigger_chk #(
  parameter int TMIN    = 850,
  parameter int TSTART  = 13000,
  parameter int TON_MIN = 20,
  parameter int TON_MAX = 600
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic gate_o,
  input logic start_o
);
  int since_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_q <= 0;
    else if (!en_i)               since_q <= 0;
    else if (start_o)             since_q <= 1;
    else if (since_q < TSTART + 2) since_q <= since_q + 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= 0;
    else if (!gate_o) hi_q <= 0;
    else              hi_q <= hi_q + 1;
  end

  a_r1_rise_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> start_o);
  a_r1_strobe_has_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> gate_o);
  a_r10_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gate_o && !start_o));
  a_r2_min_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> since_q >= TMIN);
  // one extra edge allowed for the gap counted from enable return
  a_r5_max_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q <= TSTART + 1);
  a_r6_on_time_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && $past(en_i)) |-> (hi_q >= TON_MIN && hi_q <= TON_MAX));
endmodule

bind qr_cycle_trigger qr_cycle_trigger_chk #(
  .TMIN(TMIN_CYC), .TSTART(TSTART_CYC), .TON_MIN(TON_MIN), .TON_MAX(TON_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .gate_o(gate_o), .start_o(start_o)
);

// File: tb/sim_qr_cycle_trigger.sv
module sim_qr_cycle_trigger;
  localparam int TMIN = 40, TFB = 20, TST = 200, TMN = 4, TMX = 30, TW = 6;
  localparam int NV = 9;
  // {ton for next cycle, valley offset a, valley offset b, expected period}
  localparam int VEC [NV][4] = '{
    '{ 2, 40,  0,  40},
    '{50, 55,  0,  55},
    '{30, 35,  0,  60},
    '{ 4,  0,  0, 200},
    '{15,  2,  0, 200},
    '{12, 35, 50,  50},
    '{10, 35, 60,  60},
    '{30, 39,  0,  60},
    '{10, 59,  0,  59}
  };

  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b1, valley_i = 1'b0;
  logic [TW-1:0] ton_i = TW'(10);
  logic gate_o, start_o;
  int ecnt = 0, checks = 0, errs = 0;

  qr_cycle_trigger #(
    .TMIN_CYC(TMIN), .TFB_CYC(TFB), .TSTART_CYC(TST),
    .TON_MIN(TMN), .TON_MAX(TMX), .TON_W(TW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .valley_i(valley_i),
    .ton_i(ton_i), .gate_o(gate_o), .start_o(start_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampt(input int t);
    return (t < TMN) ? TMN : (t > TMX) ? TMX : t;
  endfunction

  // Walk from rise edge r until the next start; drive valleys, measure width.
  task automatic run_vec(input int r, input int va, input int vb, input int per,
                         input int wexp, input string tag, output int r2);
    int e, w;
    bit done;
    w = 0; done = 0; e = ecnt;
    for (int n = 0; n < 3 * TST && !done; n++) begin
      e = ecnt;
      if (e > r && start_o) done = 1;
      else begin
        if (gate_o) w++;
        if (e == r + 1) chk(start_o == 1'b0, "R10 strobe width", start_o, 0);
        valley_i = (va != 0 && e + 1 == r + va) || (vb != 0 && e + 1 == r + vb);
        @(negedge clk);
      end
    end
    valley_i = 1'b0;
    r2 = e;
    chk(done, {tag, " start seen"}, done, 1);
    chk(r2 - r == per, {tag, " period"}, r2 - r, per);
    chk(r2 - r >= TMIN, "R2 min period", r2 - r, TMIN);
    chk(w == wexp, "R6 on-time", w, wexp);
    chk(gate_o == 1'b1, "R1 gate with strobe", gate_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R5 watchdog actual=%0d expected=%0d", ecnt, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int r, r2, rel, x, wexp, bad;
    string tag;
    repeat (3) @(negedge clk);
    chk(gate_o == 1'b0 && start_o == 1'b0, "R11 reset state", {gate_o, start_o}, 0);
    rst_ni = 1'b1;
    rel = ecnt;
    // boot: valley at offset 50 must be ignored, starter fires
    run_vec(rel + 1, 50, 0, TST, 0, "R9", r2);
    r = r2;
    wexp = clampt(10);
    for (int v = 0; v < NV; v++) begin
      ton_i = TW'(VEC[v][0]);
      if (VEC[v][3] == TST) tag = (VEC[v][1] != 0) ? "R7" : "R5";
      else if (VEC[v][3] == TMIN + TFB && VEC[v][1] < TMIN)
        tag = (VEC[v][2] != 0) ? "R10" : "R4";
      else tag = "R3";
      run_vec(r, VEC[v][1], VEC[v][2], VEC[v][3], wexp, tag, r2);
      wexp = clampt(VEC[v][0]);
      r = r2;
    end
    // disable while the gate is high
    en_i = 1'b0;
    @(negedge clk);
    chk(gate_o == 1'b0 && start_o == 1'b0, "R8 disable", {gate_o, start_o}, 0);
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      valley_i = i[0];
      @(negedge clk);
      if (gate_o || start_o) bad = 1;
    end
    valley_i = 1'b0;
    chk(bad == 0, "R8 quiet while disabled", bad, 0);
    x = ecnt;
    en_i = 1'b1;
    // blanking-range and late valleys during restart wait are both ignored
    run_vec(x + 1, 10, 50, TST, 0, "R9", r2);
    r = r2;
    run_vec(r, 45, 0, 45, wexp, "R3", r2);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(gate_o == 1'b0 && start_o == 1'b0, "R11 async reset", {gate_o, start_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule